// File: doc/BRIEF.md
# Accumulator Datapath with Shared Bus

This block is the execution half of a small 8-bit accumulator machine. One 8-bit bus carries both data and addresses between the program counter, a 256-word memory, the accumulator and an input value. Every clock, a 4-bit operation code from an external sequencer selects one register transfer. Each transfer completes in that single cycle, and its result is visible after the rising edge. Operation 0 is an idle cycle. The memory is read combinationally at the address register and written on the clock edge.

The block holds an accumulator, carry and zero flags, an address register, an instruction register, a program counter and an output register. The output register also latches a 4-bit port number. A condition output picks carry, zero or one of their complements, using the two low bits of the instruction register. The sequencer uses it for conditional jumps. After reset, the memory holds a computed preload pattern, so a program can run without any external loading.

Top module: `acc_bus_datapath`

## Requirements
- R1: While rst_ni is low, all registers are cleared to zero, and memory word i is set to (29*i + 7) mod 256.
- R2: Op 1 copies PC into AR and increments PC in the same cycle. PC wraps from 255 to 0.
- R3: Op 2 loads IR from memory at AR. Op 3 loads AR from memory at AR.
- R4: Op 4 loads A from memory at AR. Op 5 writes A into memory at AR.
- R5: Op 6 sets {C,A} to the 9-bit sum A + mem[AR]. Z is set exactly when the low 8 bits of the sum are zero.
- R6: Op 7 sets A to A AND mem[AR], clears C, and sets Z exactly when the result is zero.
- R7: Op 8 loads PC from memory at AR.
- R8: Op 9 complements A. Op 10 shifts {C,A} right by one: the old C enters A[7] and the old A[0] moves to C.
- R9: Op 11 loads A from in_data_i. Op 12 copies A into the output register and copies IR[3:0] into the port-number output.
- R10: cond_o equals C when IR[1:0]=00, not C when 01, Z when 10, and not Z when 11.
- R11: Op 0 and ops 13 to 15 leave every register and every memory word unchanged.
- R12: C changes only on ops 6, 7 and 10. Z changes only on ops 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation select, 0 = idle |
| in_data_i | input | 8 | Input port value, taken by op 11 |
| acc_o | output | 8 | Accumulator |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| pc_o | output | 8 | Program counter |
| addr_o | output | 8 | Address register |
| ir_o | output | 8 | Instruction register |
| out_data_o | output | 8 | Output register |
| out_port_o | output | 4 | Port number latched by op 12 |
| cond_o | output | 1 | Selected jump condition |

## Verification
Every operation updates its register on the first rising edge after op_i is applied, so each result is due exactly one edge later. cond_o follows the registers without delay, so it changes in that same cycle. The bench applies an operation 2 ns after a rising edge and keeps a behavioural model that updates at that moment. It compares every output against the model 2 ns after the next edge. It never samples on an edge, and it never waits more than one cycle. A memory write is observed through a later op 4 or op 6 that reads the same address.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [1:0] {
    BUS_MEM = 2'b00,
    BUS_PC  = 2'b01,
    BUS_ACC = 2'b10,
    BUS_IN  = 2'b11
  } bus_src_e;

  typedef enum logic [2:0] {
    ALU_PASS = 3'd0,
    ALU_ADD  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_NOT  = 3'd3,
    ALU_RRC  = 3'd4
  } alu_fn_e;

  typedef struct packed {
    bus_src_e bus_src;
    alu_fn_e  alu_fn;
    logic     ld_acc;
    logic     ld_c;
    logic     ld_z;
    logic     ld_ar;
    logic     ld_ir;
    logic     ld_pc;
    logic     inc_pc;
    logic     wr_mem;
    logic     ld_out;
  } ctrl_t;

  function automatic int unsigned mem_init_word(int unsigned idx);
    return (idx * 29 + 7) % 256;
  endfunction
endpackage

// File: rtl/acc_dp_decode.sv
module acc_dp_decode
  import acc_dp_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           ctrl_o
);
  always_comb begin
    ctrl_o         = '0;
    ctrl_o.bus_src = BUS_MEM;
    ctrl_o.alu_fn  = ALU_PASS;
    unique case (op_i)
      4'd1: begin ctrl_o.bus_src = BUS_PC; ctrl_o.ld_ar = 1'b1; ctrl_o.inc_pc = 1'b1; end
      4'd2: ctrl_o.ld_ir = 1'b1;
      4'd3: ctrl_o.ld_ar = 1'b1;
      4'd4: ctrl_o.ld_acc = 1'b1;
      4'd5: begin ctrl_o.bus_src = BUS_ACC; ctrl_o.wr_mem = 1'b1; end
      4'd6: begin
        ctrl_o.alu_fn = ALU_ADD; ctrl_o.ld_acc = 1'b1;
        ctrl_o.ld_c = 1'b1; ctrl_o.ld_z = 1'b1;
      end
      4'd7: begin
        ctrl_o.alu_fn = ALU_AND; ctrl_o.ld_acc = 1'b1;
        ctrl_o.ld_c = 1'b1; ctrl_o.ld_z = 1'b1;
      end
      4'd8: ctrl_o.ld_pc = 1'b1;
      4'd9: begin ctrl_o.alu_fn = ALU_NOT; ctrl_o.ld_acc = 1'b1; end
      4'd10: begin ctrl_o.alu_fn = ALU_RRC; ctrl_o.ld_acc = 1'b1; ctrl_o.ld_c = 1'b1; end
      4'd11: begin ctrl_o.bus_src = BUS_IN; ctrl_o.ld_acc = 1'b1; end
      4'd12: begin ctrl_o.bus_src = BUS_ACC; ctrl_o.ld_out = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_dp_alu.sv
module acc_dp_alu
  import acc_dp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  alu_fn_e       fn_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          c_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          z_o
);
  logic [DW:0] sum;

  always_comb begin
    sum   = {1'b0, a_i} + {1'b0, b_i};
    res_o = b_i;
    c_o   = c_i;
    unique case (fn_i)
      ALU_ADD: {c_o, res_o} = sum;
      ALU_AND: begin res_o = a_i & b_i; c_o = 1'b0; end
      ALU_NOT: res_o = ~a_i;
      ALU_RRC: begin res_o = {c_i, a_i[DW-1:1]}; c_o = a_i[0]; end
      default: ;
    endcase
    z_o = (res_o == '0);
  end
endmodule

// File: rtl/acc_dp_mem.sv
module acc_dp_mem #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= DW'(acc_dp_pkg::mem_init_word(i));
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];

  AST_MEM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(addr_i)] == $past(wdata_i)); // R4
endmodule

// File: rtl/acc_bus_datapath.sv
module acc_bus_datapath
  import acc_dp_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned PW   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   in_data_i,
  output logic [DW-1:0]   acc_o,
  output logic            carry_o,
  output logic            zero_o,
  output logic [DW-1:0]   pc_o,
  output logic [DW-1:0]   addr_o,
  output logic [DW-1:0]   ir_o,
  output logic [DW-1:0]   out_data_o,
  output logic [PW-1:0]   out_port_o,
  output logic            cond_o
);
  localparam int unsigned AW = DW;

  ctrl_t         ctrl;
  logic [DW-1:0] bus, mem_rdata, alu_res;
  logic          alu_c, alu_z;
  logic [DW-1:0] acc_q, pc_q, ar_q, ir_q, out_q;
  logic [PW-1:0] port_q;
  logic          c_q, z_q;

  acc_dp_decode u_decode (.op_i(op_i), .ctrl_o(ctrl));

  acc_dp_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctrl.wr_mem),
    .addr_i (ar_q),
    .wdata_i(bus),
    .rdata_o(mem_rdata)
  );

  always_comb begin
    unique case (ctrl.bus_src)
      BUS_PC:  bus = pc_q;
      BUS_ACC: bus = acc_q;
      BUS_IN:  bus = in_data_i;
      default: bus = mem_rdata;
    endcase
  end

  acc_dp_alu #(.DW(DW)) u_alu (
    .fn_i (ctrl.alu_fn),
    .a_i  (acc_q),
    .b_i  (bus),
    .c_i  (c_q),
    .res_o(alu_res),
    .c_o  (alu_c),
    .z_o  (alu_z)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      pc_q   <= '0;
      ar_q   <= '0;
      ir_q   <= '0;
      out_q  <= '0;
      port_q <= '0;
      c_q    <= 1'b0;
      z_q    <= 1'b0;
    end else begin
      if (ctrl.ld_acc) acc_q <= alu_res;
      if (ctrl.ld_c)   c_q   <= alu_c;
      if (ctrl.ld_z)   z_q   <= alu_z;
      if (ctrl.ld_ar)  ar_q  <= bus;
      if (ctrl.ld_ir)  ir_q  <= bus;
      if (ctrl.ld_pc)       pc_q <= bus;
      else if (ctrl.inc_pc) pc_q <= pc_q + 1'b1;
      if (ctrl.ld_out) begin
        out_q  <= bus;
        port_q <= ir_q[PW-1:0];
      end
    end
  end

  // Jump condition select on IR[1:0]
  always_comb begin
    unique case (ir_q[1:0])
      2'b00:   cond_o = c_q;
      2'b01:   cond_o = ~c_q;
      2'b10:   cond_o = z_q;
      default: cond_o = ~z_q;
    endcase
  end

  assign acc_o      = acc_q;
  assign carry_o    = c_q;
  assign zero_o     = z_q;
  assign pc_o       = pc_q;
  assign addr_o     = ar_q;
  assign ir_o       = ir_q;
  assign out_data_o = out_q;
  assign out_port_o = port_q;

  AST_FETCH_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 4'd1 |=> pc_o == $past(pc_o) + 1'b1 && addr_o == $past(pc_o)); // R2
  AST_AND_CLR_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 4'd7 |=> !carry_o); // R6
  AST_RRC_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 4'd10 |=> carry_o == $past(acc_o[0]) && acc_o[DW-1] == $past(carry_o)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd0 || op_i > 4'd12) |=> $stable(acc_o) && $stable(pc_o) && $stable(addr_o)
      && $stable(ir_o) && $stable(out_data_o) && $stable(carry_o) && $stable(zero_o)); // R11
  AST_Z_ONLY_ALU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(op_i == 4'd6 || op_i == 4'd7) |=> $stable(zero_o)); // R12
endmodule

// File: tb/acc_bus_datapath_tb.sv
module acc_bus_datapath_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] din = '0;
  logic [7:0] acc, pc, ar, ir, outd;
  logic [3:0] oport;
  logic       cy, zf, cnd;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // reference state
  logic [7:0] m_mem [256];
  logic [7:0] m_acc, m_pc, m_ar, m_ir, m_out;
  logic [3:0] m_port;
  logic       m_c, m_z;

  always #4 clk = ~clk;

  acc_bus_datapath u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .in_data_i(din),
    .acc_o(acc), .carry_o(cy), .zero_o(zf), .pc_o(pc), .addr_o(ar),
    .ir_o(ir), .out_data_o(outd), .out_port_o(oport), .cond_o(cnd)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      4'd9, 4'd10: return "R8";
      4'd11, 4'd12: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic compare(input string req);
    logic exp_f;
    chk(req, "acc", acc, m_acc);
    chk(req, "pc", pc, m_pc);
    chk(req, "ar", ar, m_ar);
    chk(req, "ir", ir, m_ir);
    chk(req, "out", outd, m_out);
    chk(req, "port", oport, m_port);
    chk((req == "R5" || req == "R6" || req == "R8") ? req : "R12", "carry", cy, m_c);
    chk((req == "R5" || req == "R6") ? req : "R12", "zero", zf, m_z);
    case (m_ir[1:0])
      2'b00: exp_f = m_c;
      2'b01: exp_f = !m_c;
      2'b10: exp_f = m_z;
      default: exp_f = !m_z;
    endcase
    chk("R10", "cond", cnd, exp_f);
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) m_mem[i] = 8'((i * 29 + 7) % 256);
    m_acc = 0; m_pc = 0; m_ar = 0; m_ir = 0; m_out = 0; m_port = 0; m_c = 0; m_z = 0;
  endtask

  task automatic model_apply(input logic [3:0] o, input logic [7:0] d);
    int s;
    logic [7:0] rd;
    rd = m_mem[m_ar];
    case (o)
      4'd1: begin m_ar = m_pc; m_pc = m_pc + 8'd1; end
      4'd2: m_ir = rd;
      4'd3: m_ar = rd;
      4'd4: m_acc = rd;
      4'd5: m_mem[m_ar] = m_acc;
      4'd6: begin s = int'(m_acc) + int'(rd); m_acc = 8'(s); m_c = s > 255; m_z = (s % 256) == 0; end
      4'd7: begin m_acc = m_acc & rd; m_c = 0; m_z = m_acc == 0; end
      4'd8: m_pc = rd;
      4'd9: m_acc = ~m_acc;
      4'd10: begin s = m_acc[0]; m_acc = {m_c, m_acc[7:1]}; m_c = s[0]; end
      4'd11: m_acc = d;
      4'd12: begin m_out = m_acc; m_port = m_ir[3:0]; end
      default: ;
    endcase
  endtask

  task automatic step(input logic [3:0] o, input logic [7:0] d);
    op = o; din = d;
    model_apply(o, d);
    @(posedge clk); #2;
    compare(req_of(o));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    model_reset();
    #3;
    compare("R1");
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(posedge clk); #2;
    compare("R1");
    // R1: preload pattern visible through op4 at address 0 and mem[0]=7
    step(4'd1, 0); step(4'd4, 0);
    chk("R1", "mem0", acc, 7);
    // R3: indirect address chain
    step(4'd3, 0); step(4'd4, 0); step(4'd3, 0); step(4'd2, 0);
    // R9: input load and output with port
    step(4'd11, 8'hA5); step(4'd12, 0);
    // R4: write then read back
    step(4'd5, 0); step(4'd11, 8'h00); step(4'd4, 0);
    chk("R4", "readback", acc, 8'hA5);
    // R5: add with carry-out and zero result
    step(4'd11, 8'h00); step(4'd1, 0); step(4'd11, 8'hFF); step(4'd5, 0);
    step(4'd11, 8'h01); step(4'd6, 0);
    chk("R5", "sum_zero", {cy, zf}, 2'b11);
    // R8: rotate carry into bit 7
    step(4'd10, 0); chk("R8", "rrc", acc, 8'h80);
    step(4'd9, 0); chk("R8", "cpl", acc, 8'h7F);
    // R6: AND clears carry
    step(4'd6, 0); step(4'd7, 0);
    // R11: idle codes
    step(4'd0, 8'h33); step(4'd13, 8'h33); step(4'd14, 0); step(4'd15, 0);
    // R7: jump load, and PC wrap for R2
    step(4'd11, 8'hFF); step(4'd5, 0); step(4'd8, 0);
    chk("R7", "pc_jump", pc, 8'hFF);
    step(4'd1, 0); chk("R2", "pc_wrap", pc, 0);
    // R10: every IR[1:0] value via op2 from varied addresses
    for (int k = 0; k < 8; k++) begin
      step(4'd1, 0); step(4'd2, 0); step(4'd7, 0);
    end
    // mixed stream
    lfsr = 16'hACE1;
    for (int n = 0; n < 1500; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0], lfsr[15:8]);
    end
    op = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule